// File: doc/BRIEF.md
# Dual Cascadable Down-Counting Timer

This block contains two 8-bit down-counters that share one control word. Each counter has its own reload value, a run or stop-and-load mode, an interrupt-acknowledge bit and a tick-source select. A counter can be driven by either of two fixed reference tick strobes, or by a flexible tick that comes from an internal programmable prescaler. The second counter can also be clocked by the underflows of the first, so the two counters act as one longer chain.

Every underflow reloads the counter and sets a sticky pending flag. Each interrupt line is the registered AND of that flag and a mask bit. Mask bits can only be set, through their own write register. Software uses a simple write and read port. The live counts, the prescaler value, the mask and pending state and the stored control word can all be read back.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every readback reads zero and both interrupt outputs are low.
- R2: When a counter's mode bit is 0 (stop-and-load), the counter holds its reload field on the clock after the control write. This holds even if the counter was part-way through a count.
- R3: When a counter's mode bit is 1 (run), it decrements once for each strobe of its selected source and ignores every other strobe. The select codes are 0 = reference A, 1 = reference B, 2 = flexible prescaler tick and 3 = cascade. Code 3 is valid only for counter 1; counter 0 never counts with code 3.
- R4: A tick that arrives while the count is 1 is an underflow. On the same edge the counter reloads from its reload field and its pending flag is set. The pending flag then stays set until it is acknowledged, so the period is equal to the reload value in ticks.
- R5: A reload value of 0 gives a period of 256 ticks. After 255 ticks the count reads 1, and the 256th tick underflows the counter.
- R6: A control write with a counter's acknowledge bit at 1 clears that counter's pending flag. With the bit at 0, the flag is left unchanged. The acknowledge bits are not stored.
- R7: Each interrupt output is a registered copy of pending AND mask. A write to the mask-set register sets mask bit i when data bit i is 1. A 0 bit in that write leaves the mask bit unchanged.
- R8: A prescaler write loads both the reload value and the current value. The prescaler then counts down once per clock. At 0 it emits one flexible tick and reloads, so the period is reload+1 clocks. Its current value can be read back.
- R9: When counter 1 selects cascade, it decrements once per counter-0 underflow.
- R10: The control word holds one 12-bit slice per counter, at bit 0 and bit 12. Within a slice, [7:0] is the reload value, [8] is the mode, [9] is the acknowledge bit and [11:10] is the source select. Write selects: 0 = control, 1 = prescaler, 2 = mask set. Read selects, captured one clock after rd_sel: 0 = {count1, count0} in [15:0]; 1 = prescaler current value; 2 = {mask[1:0], pending[1:0]} in [3:0]; 3 = the stored control word with the acknowledge bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Registered read data |
| tick_ref_a | input | 1 | Reference tick strobe A |
| tick_ref_b | input | 1 | Reference tick strobe B |
| irq0 | output | 1 | Counter 0 interrupt |
| irq1 | output | 1 | Counter 1 interrupt |

## Verification
On every cycle, the assertions check the following:
- Stop mode holds the reload value.
- A running counter without a tick holds its count.
- An underflow reloads the counter and sets the pending flag.
- Pending stays set until acknowledged.
- The prescaler steps down and reloads.
- An interrupt is never raised without its mask bit.

Only the bench scenarios can show the behaviour that needs whole sequences:
- the exact period in ticks, including 256 ticks for a reload of 0;
- that strobes from an unselected source are ignored;
- the cascade chain across both counters;
- the register read map.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int DIV_W  = 8;
  localparam int PRE_W  = 16;
  localparam int DATA_W = 32;
  localparam int SLICE_W = DIV_W + 4;

  typedef enum logic [1:0] {
    SRC_REF_A = 2'd0,
    SRC_REF_B = 2'd1,
    SRC_FLEX  = 2'd2,
    SRC_CHAIN = 2'd3
  } src_e;

  typedef struct packed {
    src_e             src;
    logic             ack;
    logic             run;
    logic [DIV_W-1:0] div;
  } slice_t;

  typedef enum logic [1:0] {
    WSEL_CTRL = 2'd0,
    WSEL_PRE  = 2'd1,
    WSEL_MASK = 2'd2
  } wsel_e;
endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PRE_W-1:0] load_val_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] reload_q;
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      cnt_q    <= load_val_i;
    end else if (tick_o) begin
      cnt_q <= reload_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !load_i) |=> (cnt_q == $past(reload_q))); // R8
  AST_PRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!tick_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter
  import ctp_pkg::*;
#(
  parameter int  CW          = 8,
  parameter bit  CAN_CASCADE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] div_i,
  input  logic          run_i,
  input  src_e          src_i,
  input  logic          ref_a_i,
  input  logic          ref_b_i,
  input  logic          flex_i,
  input  logic          chain_i,
  input  logic          ack_i,
  output logic [CW-1:0] cnt_o,
  output logic          uf_o,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          chain_tick;
  logic          tick;

  generate
    if (CAN_CASCADE) begin : g_chain
      assign chain_tick = chain_i;
    end else begin : g_nochain
      logic unused_chain;
      assign unused_chain = chain_i;
      assign chain_tick   = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_REF_A: tick = ref_a_i;
      SRC_REF_B: tick = ref_b_i;
      SRC_FLEX:  tick = flex_i;
      default:   tick = chain_tick;
    endcase
  end

  assign uf_o   = run_i && tick && (cnt_q == CW'(1));
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!run_i)     cnt_q <= div_i;
      else if (uf_o)  cnt_q <= div_i;
      else if (tick)  cnt_q <= cnt_q - 1'b1;
      if (uf_o)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  AST_STOP_LOADS: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == $past(div_i))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick) |=> $stable(cnt_q)); // R3
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    uf_o |=> ((cnt_q == $past(div_i)) && pend_q)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> pend_q); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !uf_o) |=> !pend_q); // R6
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_ref_a,
  input  logic              tick_ref_b,
  output logic              irq0,
  output logic              irq1
);
  localparam int N_TMR  = 2;
  localparam int CTRL_W = N_TMR * SLICE_W;
  localparam int ACK_B  = DIV_W + 1;

  logic [CTRL_W-1:0]     ctrl_q;
  logic [N_TMR-1:0]      mask_q;
  logic [N_TMR-1:0]      irq_q;
  logic [DATA_W-1:0]     rd_q;
  logic [N_TMR-1:0]      uf;
  logic [N_TMR-1:0]      pend;
  logic [N_TMR-1:0]      chain;
  logic [N_TMR-1:0]      ack;
  logic [DIV_W-1:0]      cnt [N_TMR];
  logic                  flex_tick;
  logic [PRE_W-1:0]      pre_cnt;
  logic                  wr_ctrl;
  logic                  wr_pre;
  logic                  wr_mask;
  logic                  unused_wr;

  assign wr_ctrl   = wr_en && (wr_sel == WSEL_CTRL);
  assign wr_pre    = wr_en && (wr_sel == WSEL_PRE);
  assign wr_mask   = wr_en && (wr_sel == WSEL_MASK);
  assign unused_wr = ^wr_data[DATA_W-1:CTRL_W];
  assign chain     = {uf[0], 1'b0};

  ctp_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wr_pre),
    .load_val_i (wr_data[PRE_W-1:0]),
    .tick_o     (flex_tick),
    .cnt_o      (pre_cnt)
  );

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      slice_t sl;
      assign sl     = slice_t'(ctrl_q[i*SLICE_W +: SLICE_W]);
      assign ack[i] = wr_ctrl && wr_data[i*SLICE_W + ACK_B];

      ctp_counter #(.CW(DIV_W), .CAN_CASCADE(i != 0)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .div_i   (sl.div),
        .run_i   (sl.run),
        .src_i   (sl.src),
        .ref_a_i (tick_ref_a),
        .ref_b_i (tick_ref_b),
        .flex_i  (flex_tick),
        .chain_i (chain[i]),
        .ack_i   (ack[i]),
        .cnt_o   (cnt[i]),
        .uf_o    (uf[i]),
        .pend_o  (pend[i])
      );

      AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        !mask_q[i] |=> !irq_q[i]); // R7
      AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (pend[i] && mask_q[i]) |=> irq_q[i]); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
      irq_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
        for (int i = 0; i < N_TMR; i++) ctrl_q[i*SLICE_W + ACK_B] <= 1'b0;
      end
      if (wr_mask) mask_q <= mask_q | wr_data[N_TMR-1:0];
      irq_q <= pend & mask_q;
      unique case (rd_sel)
        2'd0:    rd_q <= DATA_W'({cnt[1], cnt[0]});
        2'd1:    rd_q <= DATA_W'(pre_cnt);
        2'd2:    rd_q <= DATA_W'({mask_q, pend});
        default: rd_q <= DATA_W'(ctrl_q);
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq0    = irq_q[0];
  assign irq1    = irq_q[1];

  AST_MASK_ONLY_SETS: assert property (@(posedge clk) disable iff (rst)
    mask_q[0] |=> mask_q[0]); // R7
endmodule

// File: tb/cascade_timer_pair_tb_top.sv
`timescale 1ns/1ps
module cascade_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        tick_ref_a = 1'b0;
  logic        tick_ref_b = 1'b0;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  cascade_timer_pair dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick_ref_a(tick_ref_a),
    .tick_ref_b(tick_ref_b), .irq0(irq0), .irq1(irq1)
  );

  function automatic logic [11:0] sl(input logic [7:0] d, input logic run,
                                     input logic ack, input logic [1:0] src);
    return {src, ack, run, d};
  endfunction

  function automatic logic [31:0] cw(input logic [11:0] s0, input logic [11:0] s1);
    return {8'h0, s1, s0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    rd_sel = s;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_a(input int n);
    for (int k = 0; k < n; k++) begin
      tick_ref_a = 1'b1; @(negedge clk); tick_ref_a = 1'b0;
    end
  endtask

  task automatic pulse_b(input int n);
    for (int k = 0; k < n; k++) begin
      tick_ref_b = 1'b1; @(negedge clk); tick_ref_b = 1'b0;
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], rv); check("R1 readback zero", rv, 32'h0);
    end
    check("R1 irq low", {30'h0, irq1, irq0}, 32'h0);
  endtask

  task automatic t_prescaler;
    wr(2'd1, 32'd4);
    rd(2'd1, rv); check("R8 prescaler load", rv, 32'd4);
    rd(2'd1, rv); check("R8 prescaler step", rv, 32'd3);
    rd(2'd1, rv); rd(2'd1, rv); check("R8 prescaler step", rv, 32'd1);
    rd(2'd1, rv); check("R8 prescaler zero", rv, 32'd0);
    rd(2'd1, rv); check("R8 prescaler wrap", rv, 32'd4);
  endtask

  task automatic t_ref_a;
    wr(2'd0, cw(sl(8'd3, 1'b0, 1'b0, 2'd0), 12'h0)); idle(1);
    rd(2'd0, rv); check("R2 stop loads", rv, 32'h3);
    wr(2'd0, cw(sl(8'd3, 1'b1, 1'b0, 2'd0), 12'h0)); idle(1);
    pulse_b(1); rd(2'd0, rv); check("R3 other source ignored", rv, 32'h3);
    pulse_a(1); rd(2'd0, rv); check("R3 decrement", rv, 32'h2);
    wr(2'd0, cw(sl(8'd3, 1'b0, 1'b0, 2'd0), 12'h0)); idle(1);
    rd(2'd0, rv); check("R2 stop mid-count", rv, 32'h3);
    wr(2'd0, cw(sl(8'd3, 1'b1, 1'b0, 2'd0), 12'h0)); idle(1);
    pulse_a(2); rd(2'd0, rv); check("R4 count one", rv, 32'h1);
    rd(2'd2, rv); check("R4 no pend yet", rv, 32'h0);
    pulse_a(1); rd(2'd0, rv); check("R4 reload", rv, 32'h3);
    rd(2'd2, rv); check("R4 pend set", rv, 32'h1);
    check("R7 masked irq", {31'h0, irq0}, 32'h0);
    wr(2'd2, 32'h1); idle(2);
    check("R7 irq on mask", {31'h0, irq0}, 32'h1);
    wr(2'd2, 32'h0); idle(2);
    rd(2'd2, rv); check("R7 zero write keeps mask", rv, 32'h5);
    wr(2'd0, cw(sl(8'd3, 1'b1, 1'b0, 2'd0), 12'h0)); idle(2);
    rd(2'd2, rv); check("R6 no ack keeps pend", rv, 32'h5);
    wr(2'd0, cw(sl(8'd3, 1'b1, 1'b1, 2'd0), 12'h0)); idle(2);
    check("R6 ack drops irq", {31'h0, irq0}, 32'h0);
    rd(2'd2, rv); check("R6 ack clears pend", rv, 32'h4);
    rd(2'd3, rv); check("R10 ctrl readback", rv, cw(sl(8'd3, 1'b1, 1'b0, 2'd0), 12'h0));
  endtask

  task automatic t_div_zero;
    wr(2'd0, cw(12'h0, sl(8'd0, 1'b0, 1'b0, 2'd1))); idle(1);
    wr(2'd0, cw(12'h0, sl(8'd0, 1'b1, 1'b0, 2'd1))); idle(1);
    pulse_b(255);
    rd(2'd0, rv); check("R5 after 255", rv, 32'h0100);
    rd(2'd2, rv); check("R5 no pend at 255", rv, 32'h4);
    pulse_b(1);
    rd(2'd0, rv); check("R5 wrap at 256", rv, 32'h0000);
    rd(2'd2, rv); check("R5 pend at 256", rv, 32'h6);
    wr(2'd0, cw(12'h0, sl(8'd0, 1'b0, 1'b1, 2'd1))); idle(1);
    rd(2'd2, rv); check("R6 ack counter1", rv, 32'h4);
  endtask

  task automatic t_cascade;
    wr(2'd0, cw(sl(8'd2, 1'b0, 1'b0, 2'd0), sl(8'd3, 1'b0, 1'b0, 2'd3))); idle(1);
    wr(2'd0, cw(sl(8'd2, 1'b1, 1'b0, 2'd0), sl(8'd3, 1'b1, 1'b0, 2'd3))); idle(1);
    rd(2'd0, rv); check("R9 start", rv, 32'h0302);
    pulse_a(2); rd(2'd0, rv); check("R9 one chain tick", rv, 32'h0202);
    pulse_a(4); rd(2'd0, rv); check("R9 chained underflow", rv, 32'h0302);
    rd(2'd2, rv); check("R9 both pend", rv, 32'h7);
    wr(2'd0, cw(sl(8'd2, 1'b0, 1'b1, 2'd0), sl(8'd3, 1'b0, 1'b1, 2'd0))); idle(1);
    wr(2'd0, cw(sl(8'd2, 1'b1, 1'b0, 2'd3), 12'h0)); idle(1);
    pulse_a(3); pulse_b(3);
    rd(2'd0, rv); check("R3 counter0 code 3 idle", rv, 32'h0002);
  endtask

  task automatic t_flex;
    wr(2'd0, cw(sl(8'd10, 1'b0, 1'b0, 2'd2), 12'h0));
    wr(2'd1, 32'd0); idle(1);
    wr(2'd0, cw(sl(8'd10, 1'b1, 1'b0, 2'd2), 12'h0));
    idle(3);
    rd(2'd0, rv); check("R3 flexible source", rv, 32'h7);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_prescaler();
    t_ref_a();
    t_div_zero();
    t_cascade();
    t_flex();
    idle(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule